// File: doc/BRIEF.md
# Colour Palette Loader

This block holds a 256-entry colour lookup table, stored as three separate 8-bit arrays for red, green and blue, and fills it through a 16-byte write-only register window. A host first writes the entry number to the index register. It then writes three words in a row to the data register: the first goes to red, the second to green and the third to blue. A small sequencer tracks which component comes next. Only the most significant byte of each 32-bit write carries data.

After the blue write the sequencer goes back to red, but the index stays where it is. A second triplet with no new index write therefore replaces the same entry. A pixel pipeline reads the table through a separate lookup port. It gives an 8-bit pixel value and gets the 24-bit colour back in the same cycle, without waiting for a clock edge.

Top module: `pal_loader_top`

## Requirements
- R1: The register is chosen by byte address bits 3:2. Slot 0 (address 0x0) is the index register and slot 1 (address 0x4) is the data register. Address bits 1:0 are ignored.
- R2: A write to slot 0 loads the index from write data bits 31:24 and returns the sequencer to the red state.
- R3: Writes to slot 1 store write data bits 31:24 at the current index: first into red, then green, then blue. On the lookup port, red is bits 23:16, green is 15:8 and blue is 7:0.
- R4: After the blue write the sequencer returns to red and the index is unchanged, so a following triplet overwrites the same entry.
- R5: Writes to slots 2 and 3 change no palette entry, index or sequencer state.
- R6: A read anywhere in the window returns zero.
- R7: A synchronous active-low reset sets every entry to 0x000000 except entry 255, which becomes 0xFFFFFF. It also clears the index and the sequencer to zero.
- R8: The lookup port is combinational. A write and a lookup of the same entry in the same cycle return the value from before the write, and the new value shows from the next cycle.
- R9: A write takes effect only in a cycle where the write strobe is high. Write data bits 23:0 have no effect.
- R10: A slot 0 write in the middle of a triplet abandons it: the next slot 1 write goes to red at the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address within the window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| px_index | input | 8 | Pixel value to look up |
| px_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
The hardest case to reach is a triplet that starts again part-way through: a slot 0 write that lands after red or green, mixed with writes to the ignored slots. The sequencer state is not visible at the ports. The random stream mixes index writes, data writes and ignored-slot writes with random low address and data bits, so the sequencer is caught in every phase. A bench model of the palette is compared against the lookup port at intervals and across the whole table at the end. Directed sequences cover the reset contents, a repeated triplet without a new index, and a write and lookup of the same entry in the same cycle.

// File: rtl/pal_pkg.sv
// Package: shared types for the palette loader.
// Assumes: 32-bit host data, the colour byte in the top byte of the word.
package pal_pkg;
    localparam int BUS_W     = 32;
    localparam int WIN_ADDR_W = 4;

    // Register slot selected by byte address bits 3:2
    typedef enum logic [1:0] {
        SLOT_INDEX = 2'd0,
        SLOT_DATA  = 2'd1,
        SLOT_RSV2  = 2'd2,
        SLOT_RSV3  = 2'd3
    } slot_e;

    // Next colour component expected on the data register
    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;
endpackage

// File: rtl/pal_reg_ctrl.sv
// Module: pal_reg_ctrl
// Decodes host writes to the register window. Holds the entry index and the
// component sequencer, and raises one write enable per colour array.
// Assumes: one write per cycle with bus_wr high; reads are handled at the top.
module pal_reg_ctrl
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        slot,
    input  logic [COMP_W-1:0] wbyte,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        comp_we,
    output logic [COMP_W-1:0] comp_data
);
    comp_e             state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_index;
    logic              wr_data;

    // Slot decode of the current write
    always_comb begin
        wr_index = wr && (slot_e'(slot) == SLOT_INDEX);
        wr_data  = wr && (slot_e'(slot) == SLOT_DATA);
    end

    // Index register: loaded only by slot 0 writes
    always_ff @(posedge clk) begin
        if (!rst_n)        idx_q <= '0;
        else if (wr_index) idx_q <= wbyte[IDX_W-1:0];
    end

    // Component sequencer: red, green, blue, then back to red
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= COMP_RED;
        else if (wr_index)  state_q <= COMP_RED;
        else if (wr_data) begin
            case (state_q)
                COMP_RED:   state_q <= COMP_GREEN;
                COMP_GREEN: state_q <= COMP_BLUE;
                default:    state_q <= COMP_RED;
            endcase
        end
    end

    // One-hot array enable: bit 0 red, bit 1 green, bit 2 blue
    always_comb begin
        comp_we = 3'b000;
        if (wr_data) begin
            case (state_q)
                COMP_RED:   comp_we = 3'b001;
                COMP_GREEN: comp_we = 3'b010;
                default:    comp_we = 3'b100;
            endcase
        end
    end

    assign idx       = idx_q;
    assign comp_data = wbyte;

    AST_SEQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != comp_e'(2'd3));                                       // R3
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index |=> idx_q == $past(wbyte[IDX_W-1:0]));                  // R2
    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index |=> state_q == COMP_RED);                               // R10
    AST_IDX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_index |=> $stable(idx_q));                                   // R4
    AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && state_q == COMP_BLUE) |=> state_q == COMP_RED);      // R4
    AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && slot[1]) |=> ($stable(state_q) && $stable(idx_q)));       // R5
    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(comp_we));                                              // R3
endmodule

// File: rtl/pal_color_bank.sv
// Module: pal_color_bank
// One colour component array with a synchronous write and a combinational read.
// Reset fills it with zero, except the last entry, which becomes all ones.
// Assumes: a read of the entry being written returns the old content.
module pal_color_bank #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COMP_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COMP_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COMP_W-1:0] mem_q [DEPTH];

    // Storage: reset image, then single-entry writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= (i == DEPTH - 1) ? {COMP_W{1'b1}} : {COMP_W{1'b0}};
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Lookup: combinational read of the stored value
    assign rdata = mem_q[raddr];

    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));                     // R3
    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> mem_q[$past(raddr)] == $past(rdata));                    // R9
endmodule

// File: rtl/pal_loader_top.sv
// Module: pal_loader_top
// Palette loader: a register window for the host and a combinational
// colour lookup for the pixel pipeline.
// Assumes: the window is 16 bytes; reads return zero and have no side effects.
module pal_loader_top
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [IDX_W-1:0]      px_index,
    output logic [3*COMP_W-1:0]   px_rgb
);
    localparam int NCOMP = 3;

    logic [IDX_W-1:0]  idx;
    logic [NCOMP-1:0]  comp_we;
    logic [COMP_W-1:0] comp_data;
    logic [COMP_W-1:0] comp_rd [NCOMP];
    logic              unused_bits;

    // Inputs that carry no function: read strobe, byte offset, low data bits
    assign unused_bits = ^{bus_rd, bus_addr[1:0], bus_wdata[BUS_W-COMP_W-1:0]};

    pal_reg_ctrl #(.IDX_W(IDX_W), .COMP_W(COMP_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .slot      (bus_addr[3:2]),
        .wbyte     (bus_wdata[BUS_W-1 -: COMP_W]),
        .idx       (idx),
        .comp_we   (comp_we),
        .comp_data (comp_data)
    );

    // One bank per component; component 0 (red) sits in the top bits
    for (genvar c = 0; c < NCOMP; c++) begin : g_bank
        pal_color_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W)) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (comp_we[c]),
            .waddr (idx),
            .wdata (comp_data),
            .raddr (px_index),
            .rdata (comp_rd[c])
        );
        assign px_rgb[(NCOMP-c)*COMP_W-1 -: COMP_W] = comp_rd[c];
    end

    // The window is write-only
    assign bus_rdata = '0;
endmodule

// File: tb/test_pal_loader_top.sv
module test_pal_loader_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  px_index = '0;
    logic [23:0] px_rgb;

    int checks = 0;
    int failures = 0;

    logic [23:0] m_pal [256];
    logic [7:0]  m_idx;
    int          m_st;

    always #2 clk = ~clk;

    pal_loader_top i_pal_loader_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .px_index(px_index), .px_rgb(px_rgb)
    );

    function automatic logic [23:0] reset_entry(input int i);
        return (i == 255) ? 24'hFFFFFF : 24'h000000;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 256; i++) m_pal[i] = reset_entry(i);
        m_idx = 8'd0;
        m_st  = 0;
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [31:0] d);
        case (a[3:2])
            2'd0: begin m_idx = d[31:24]; m_st = 0; end
            2'd1: begin
                case (m_st)
                    0: m_pal[m_idx][23:16] = d[31:24];
                    1: m_pal[m_idx][15:8]  = d[31:24];
                    default: m_pal[m_idx][7:0] = d[31:24];
                endcase
                m_st = (m_st == 2) ? 0 : m_st + 1;
            end
            default: ;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic look(input logic [7:0] i, input string req);
        @(negedge clk);
        px_index = i;
        #1 check(req, {8'h0, px_rgb}, {8'h0, m_pal[i]});
    endtask

    // R8: write and lookup of the same entry in one cycle
    task automatic same_cycle(input logic [31:0] d);
        logic [23:0] old;
        @(negedge clk);
        old = m_pal[m_idx];
        px_index = m_idx;
        bus_addr = 4'h4; bus_wdata = d; bus_wr = 1'b1;
        #1 check("R8 old value during write", {8'h0, px_rgb}, {8'h0, old});
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(4'h4, d);
        #1 check("R8 new value next cycle", {8'h0, px_rgb}, {8'h0, m_pal[px_index]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset contents, all entries
        for (int i = 0; i < 256; i++) look(i[7:0], "R7 reset entry");
        // R7: index and sequencer zero after reset
        bus_write(4'h4, 32'h11_ABCDEF);
        look(8'd0, "R7 index 0, red first");

        // R2/R3: load entry 0x10 with a triplet, noisy low bits (R9)
        bus_write(4'h0, 32'h10_FFFFFF);
        bus_write(4'h4, 32'hA1_123456);
        bus_write(4'h5, 32'hB2_000000);
        bus_write(4'h6, 32'hC3_FFFFFF);
        look(8'h10, "R3 triplet at 0x10");
        // R4: repeated triplet overwrites same entry
        bus_write(4'h4, 32'h01_000000);
        bus_write(4'h4, 32'h02_000000);
        bus_write(4'h4, 32'h03_000000);
        look(8'h10, "R4 same entry overwritten");
        check("R4 expected content", {8'h0, m_pal[8'h10]}, 32'h00010203);
        look(8'h11, "R4 next entry untouched");

        // R10: restart mid triplet
        bus_write(4'h4, 32'h55_000000);
        bus_write(4'h0, 32'h20_000000);
        bus_write(4'h4, 32'h77_000000);
        look(8'h20, "R10 restart at red");
        look(8'h10, "R10 old entry partial");

        // R5: reserved slots ignored, sequencer kept at green
        bus_write(4'h8, 32'h99_000000);
        bus_write(4'hC, 32'h00_000000);
        bus_write(4'h4, 32'h66_000000);
        look(8'h20, "R5 reserved slots ignored");
        look(8'h99, "R5 no index load");

        // R9: data on the bus without strobe
        @(negedge clk);
        bus_addr = 4'h4; bus_wdata = 32'hEE_000000;
        @(negedge clk);
        look(8'h20, "R9 no strobe no write");

        // R1: byte offset ignored for the index slot
        bus_write(4'h3, 32'hFF_000000);
        bus_write(4'h4, 32'h12_000000);
        look(8'hFF, "R1 offset ignored");

        // R6: reads return zero
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bus_rd = 1'b1; bus_addr = 4'(k * 4 + 1);
            #1 check("R6 read zero", bus_rdata, 32'h0);
            @(negedge clk);
            bus_rd = 1'b0;
        end

        same_cycle(32'h5A_000000);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom % 8;
            case (op)
                0: bus_write({2'd0, 2'($urandom)}, $urandom);
                1, 2, 3, 4: bus_write({2'd1, 2'($urandom)}, $urandom);
                5: bus_write({2'd2 + 2'($urandom % 2), 2'($urandom)}, $urandom);
                6: begin
                    @(negedge clk);
                    bus_rd = 1'b1; bus_addr = 4'($urandom);
                    #1 check("R6 random read zero", bus_rdata, 32'h0);
                    @(negedge clk);
                    bus_rd = 1'b0;
                end
                default: look(8'($urandom), "R3 random lookup");
            endcase
        end
        for (int i = 0; i < 256; i++) look(i[7:0], "R4 final palette");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule